// File: doc/BRIEF.md
# Filtered Trigger Start Controller

This block decides when a low-power counter begins counting and when a counter already in motion is thrown back to zero. One of eight external trigger lines is picked by a select code. The picked line passes through a digital glitch filter whose stability window is chosen by a code. An edge detector then watches the filtered level for the configured active edge. In the software mode, a start request input takes the place of the lines.

The block produces three outputs. The first is a one-cycle start pulse, issued when the counter is idle. The second is a one-cycle reset-and-restart pulse for the main counter and its repetition counter. It is issued when the counter is already running and the restart option is on. The third is a running flag that tracks whether the counter has been started. A synchronous stop input and an enable input clear the flag. All configuration inputs are static. The trigger lines are assumed to be synchronous to the kernel clock already.

Top module: `trig_start_ctrl`

## Requirements
- R1: After reset, `start_o`, `restart_o` and `running_o` are all 0, and the filtered level starts at 0.
- R2: `trig_sel_i` selects which of `trig_lines_i[7:0]` is used (value n picks bit n). Activity on any other line has no effect on the outputs.
- R3: `flt_code_i` sets the filter window: 0 gives 1 cycle, 1 gives 2, 2 gives 4 and 3 gives 8 cycles. The selected line must differ from the filtered level for that many consecutive clock samples before the filtered level follows it. A shorter excursion is discarded.
- R4: `trig_mode_i` selects the start source. 0 means software: a rising edge of `sw_start_i` is the event and the lines are ignored. 1 means a rising filtered edge, 2 a falling filtered edge, and 3 either edge. In modes 1 to 3, `sw_start_i` is ignored.
- R5: An event that occurs while `running_o` is 0, with `enable_i` high and `stop_i` low, produces `start_o` for one cycle. With window W, if the line changes before sampling edge k, `start_o` is high in the cycle after edge k+W.
- R6: `running_o` rises together with `start_o` and stays high until it is cleared.
- R7: With `restart_en_i`=1, an event that occurs while running produces a one-cycle `restart_o`, and `running_o` stays 1.
- R8: With `restart_en_i`=0, an event that occurs while running is ignored: no pulse is produced, and `running_o` stays 1.
- R9: `stop_i`=1 or `enable_i`=0 clears `running_o` at the next edge and suppresses any pulse in that cycle.
- R10: A `sw_start_i` held high yields a single event, so `start_o` is never high in two consecutive cycles.
- R11: `start_o` and `restart_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low clears running |
| trig_lines_i | input | 8 | External trigger lines, kernel-synchronous |
| trig_sel_i | input | 3 | Trigger line select |
| flt_code_i | input | 2 | Filter window code |
| trig_mode_i | input | 2 | Start source and edge code |
| restart_en_i | input | 1 | Trigger while running restarts the count |
| sw_start_i | input | 1 | Software start request (rising edge) |
| stop_i | input | 1 | Synchronous stop, clears running |
| start_o | output | 1 | One-cycle start pulse |
| restart_o | output | 1 | One-cycle reset-and-restart pulse |
| running_o | output | 1 | Counter has been started |

## Verification
A stuck or miscounted filter counter shows up at the ports as a start or restart pulse that is one or more cycles early or late. It can also show up as a pulse that should not be there, such as one caused by a glitch that ought to be rejected. The cycle-accurate reference in the bench catches either case at the first edge after the filtered level should have moved. A wrong running flag makes the block choose between start and restart wrongly, and this is visible on the first event after the flag goes bad. A stale edge or request register shows as a missing pulse or a repeated one in the cycle right after the event.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    TRG_SW   = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trg_mode_e;
endpackage

// File: rtl/tsc_line_mux.sv
module tsc_line_mux #(
  parameter int N_LINES = 8,
  parameter int SEL_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               line_o
);
  logic [N_LINES-1:0] hit;

  for (genvar i = 0; i < N_LINES; i++) begin : g_sel
    assign hit[i] = lines_i[i] && (sel_i == SEL_W'(i));
  end

  assign line_o = |hit;
endmodule

// File: rtl/tsc_glitch_filter.sv
module tsc_glitch_filter #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              lvl_o
);
  localparam int MAX_WIN = 1 << ((1 << CODE_W) - 1);
  localparam int CNT_W   = (MAX_WIN > 2) ? $clog2(MAX_WIN) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_m1;
  logic             lvl_q;

  // window is 2**code samples, code 0 means a single sample
  always_comb begin
    if (code_i == '0) win_m1 = '0;
    else              win_m1 = CNT_W'((1 << code_i) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= win_m1) begin
      lvl_q <= raw_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/tsc_edge_det.sv
module tsc_edge_det
  import tsc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  trg_mode_e mode_i,
  output logic      ev_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      TRG_RISE: ev_o = rise;
      TRG_FALL: ev_o = fall;
      TRG_BOTH: ev_o = rise | fall;
      default:  ev_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsc_start_fsm.sv
module tsc_start_fsm
  import tsc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  logic      stop_i,
  input  logic      restart_en_i,
  input  trg_mode_e mode_i,
  input  logic      hw_ev_i,
  input  logic      sw_start_i,
  output logic      start_o,
  output logic      restart_o,
  output logic      running_o
);
  logic sw_prev_q, sw_ev, ev, live;
  logic run_q, start_q, restart_q;

  assign sw_ev = sw_start_i & ~sw_prev_q;
  assign ev    = (mode_i == TRG_SW) ? sw_ev : hw_ev_i;
  assign live  = enable_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_prev_q <= 1'b0;
      run_q     <= 1'b0;
      start_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      sw_prev_q <= sw_start_i;
      start_q   <= live & ev & ~run_q;
      restart_q <= live & ev & run_q & restart_en_i;
      if (!live)   run_q <= 1'b0;
      else if (ev) run_q <= 1'b1;
    end
  end

  assign start_o   = start_q;
  assign restart_o = restart_q;
  assign running_o = run_q;
endmodule

// File: rtl/trig_start_ctrl.sv
module trig_start_ctrl
  import tsc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int SEL_W   = $clog2(N_LINES),
  parameter int CODE_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [N_LINES-1:0] trig_lines_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic [CODE_W-1:0]  flt_code_i,
  input  logic [1:0]         trig_mode_i,
  input  logic               restart_en_i,
  input  logic               sw_start_i,
  input  logic               stop_i,
  output logic               start_o,
  output logic               restart_o,
  output logic               running_o
);
  logic      raw_line, flt_lvl, hw_ev;
  trg_mode_e mode;

  assign mode = trg_mode_e'(trig_mode_i);

  tsc_line_mux #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_mux (
    .lines_i(trig_lines_i), .sel_i(trig_sel_i), .line_o(raw_line)
  );

  tsc_glitch_filter #(.CODE_W(CODE_W)) u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_line),
    .code_i(flt_code_i), .lvl_o(flt_lvl)
  );

  tsc_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(flt_lvl),
    .mode_i(mode), .ev_o(hw_ev)
  );

  tsc_start_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .stop_i(stop_i),
    .restart_en_i(restart_en_i), .mode_i(mode), .hw_ev_i(hw_ev),
    .sw_start_i(sw_start_i), .start_o(start_o), .restart_o(restart_o),
    .running_o(running_o)
  );
endmodule

// File: rtl/trig_start_ctrl_chk.sv
module trig_start_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic stop_i,
  input logic restart_en_i,
  input logic start_o,
  input logic restart_o,
  input logic running_o
);
  AST_EXCL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && restart_o)); // R11
  AST_START_SETS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> running_o); // R6
  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(running_o)); // R5
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R10
  AST_RESTART_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(restart_en_i) && $past(running_o)); // R7
  AST_NO_RESTART_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !restart_en_i) |=> !restart_o); // R8
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || !enable_i) |=> !running_o && !start_o && !restart_o); // R9
endmodule

bind trig_start_ctrl trig_start_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .stop_i(stop_i),
  .restart_en_i(restart_en_i), .start_o(start_o), .restart_o(restart_o),
  .running_o(running_o)
);

// File: tb/trig_start_ctrl_tb.sv
module trig_start_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] lines = '0;
  logic [2:0] sel = '0;
  logic [1:0] code = '0;
  logic [1:0] mode = '0;
  logic       rten = 1'b0;
  logic       sw = 1'b0;
  logic       stop = 1'b0;
  logic       start_o, restart_o, running_o;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int n_restart = 0;

  always #10 clk = ~clk;

  trig_start_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .trig_lines_i(lines),
    .trig_sel_i(sel), .flt_code_i(code), .trig_mode_i(mode),
    .restart_en_i(rten), .sw_start_i(sw), .stop_i(stop),
    .start_o(start_o), .restart_o(restart_o), .running_o(running_o)
  );

  // behavioural reference
  bit m_lvl, m_prev, m_swp, m_run, m_start, m_restart;
  int m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_prev = 0; m_swp = 0; m_run = 0;
      m_start = 0; m_restart = 0; m_hold = 0;
    end else begin
      bit raw, ev, ok;
      int win;
      raw = lines[sel];
      win = (code == 0) ? 1 : (1 << code);
      case (mode)
        2'd0: ev = sw && !m_swp;
        2'd1: ev = m_lvl && !m_prev;
        2'd2: ev = !m_lvl && m_prev;
        default: ev = m_lvl != m_prev;
      endcase
      ok = en && !stop;
      m_start   = ok && ev && !m_run;
      m_restart = ok && ev && m_run && rten;
      if (!ok) m_run = 0;
      else if (ev) m_run = 1;
      m_prev = m_lvl;
      m_swp  = sw;
      if (raw != m_lvl) begin
        m_hold++;
        if (m_hold >= win) begin m_lvl = raw; m_hold = 0; end
      end else m_hold = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5", "start_o", start_o, m_start);
      chk("R7", "restart_o", restart_o, m_restart);
      chk("R6", "running_o", running_o, m_run);
      if (start_o) n_start++;
      if (restart_o) n_restart++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #200000000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0, r0;
    step(2);
    chk("R1", "start_o reset", start_o, 0);
    chk("R1", "restart_o reset", restart_o, 0);
    chk("R1", "running_o reset", running_o, 0);
    rst_n = 1; en = 1; mode = 2'd1; code = 0; sel = 3'd2;
    step(2);
    // R2: unselected line
    lines[5] = 1; step(3); lines[5] = 0; step(4);
    chk("R2", "running after other line", running_o, 0);
    chk("R2", "starts after other line", n_start, 0);
    // R5 exact timing, code 0: high in cycle after edge k+1
    lines[2] = 1; step(1);
    chk("R5", "start not yet", start_o, 0);
    step(1);
    chk("R5", "start at k+1", start_o, 1);
    chk("R6", "running with start", running_o, 1);
    step(1);
    chk("R10", "start single cycle", start_o, 0);
    lines[2] = 0; step(3);
    // R9 stop
    stop = 1; step(1); stop = 0; step(1);
    chk("R9", "stop clears running", running_o, 0);
    // R3 code 2 window 4
    code = 2'd2; s0 = n_start;
    lines[2] = 1; step(3); lines[2] = 0; step(8);
    chk("R3", "3-cycle glitch rejected", n_start, s0);
    lines[2] = 1; step(4);
    chk("R3", "not before window+1", n_start, s0);
    step(1);
    chk("R3", "start after 4-cycle hold", n_start, s0 + 1);
    step(3);
    // R7 restart, both edges
    rten = 1; mode = 2'd3; code = 0; r0 = n_restart;
    lines[2] = 0; step(3); lines[2] = 1; step(3);
    chk("R7", "two restarts", n_restart, r0 + 2);
    chk("R7", "still running", running_o, 1);
    // R8 ignored
    rten = 0; r0 = n_restart; s0 = n_start;
    lines[2] = 0; step(3); lines[2] = 1; step(3);
    chk("R8", "no restart", n_restart, r0);
    chk("R8", "no start", n_start, s0);
    chk("R8", "still running", running_o, 1);
    // R9 disable
    en = 0; step(2);
    chk("R9", "disable clears running", running_o, 0);
    en = 1;
    // R4 software mode
    mode = 2'd0; s0 = n_start;
    lines[2] = 0; step(3); lines[2] = 1; step(3);
    chk("R4", "lines ignored in sw mode", n_start, s0);
    sw = 1; step(6); sw = 0; step(2);
    chk("R10", "held sw gives one start", n_start, s0 + 1);
    chk("R4", "sw start running", running_o, 1);
    // R4 sw ignored in hw mode
    stop = 1; step(1); stop = 0; mode = 2'd2; code = 2'd3; step(2);
    s0 = n_start;
    sw = 1; step(3); sw = 0; step(2);
    chk("R4", "sw ignored in hw mode", n_start, s0);
    // R3/R4 falling edge, window 8
    lines[2] = 0; step(7); lines[2] = 1; step(10);
    chk("R3", "7-cycle low rejected", n_start, s0);
    lines[2] = 0; step(10);
    chk("R4", "falling edge start", n_start, s0 + 1);
    // R11 covered continuously by the model compare
    chk("R11", "no overlap seen", (start_o && restart_o) ? 1 : 0, 0);
    step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule